// File: doc/BRIEF.md
# Alternate-Byte Peripheral Move Sequencer

This block carries out one peripheral-move instruction. A data register of 16 or 32 bits is spread over, or gathered from, a run of bytes whose addresses step by two. An 8-bit device wired to only one half of a 16-bit bus therefore sees every byte of the register on its own lane.

The host presents the opcode word, its 16-bit displacement extension, the value of the selected address register and the contents of the data register, then pulses `start`. The block checks the opcode and adds the displacement to the address register value. It then issues one byte request at a time on a request/acknowledge interface. When the last byte is acknowledged it pulses `done`. For loads it also hands back the new register value together with the register number to write.

Top module: `altbyte_move_seq`

## Requirements
- R1: A `start` is accepted only when `(opcode & 0xF1F8)` is one of 0x0108, 0x0148, 0x0188 or 0x01C8. Any other opcode is ignored: `busy` stays low and no memory request is issued.
- R2: `areg_sel` equals opcode bits 2..0 at all times. `result_sel` gives the data register number taken from opcode bits 11..9 when the transfer was accepted.
- R3: Opcode bits 8..6 form the opmode. Bit 6 = 1 gives four byte accesses and bit 6 = 0 gives two. Bit 7 = 1 makes every access a write (`mem_we` = 1); bit 7 = 0 makes every access a read.
- R4: The first access address is `areg_val` plus the displacement sign-extended to the address width.
- R5: Each later access uses the previous address plus 2. The address of the final access is not advanced further.
- R6: On a store the bytes are sent most significant first: bits 31..24, 23..16, 15..8, 7..0 for four bytes, and bits 15..8, 7..0 for two.
- R7: On a load the first byte read ends up as the most significant byte of the loaded part. A two-byte load replaces only bits 15..0, and bits 31..16 keep their `dreg_val` value.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the final acknowledge. `result_we` is high with `done` for loads and low for stores.
- R10: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` received while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request to execute the presented opcode |
| opcode | input | 16 | Instruction word |
| disp | input | 16 | Signed displacement extension word |
| areg_val | input | ADDR_W | Value of the selected address register |
| dreg_val | input | 32 | Contents of the data register |
| areg_sel | output | 3 | Address register number decoded from `opcode` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |
| result_we | output | 1 | Write the result back to the data register |
| result | output | 32 | New data register value |
| result_sel | output | 3 | Data register number for the write-back |

## Verification
A wrong byte counter shows at the ports as too many or too few requests, or as a byte from the wrong lane in the first write. The access log catches this on the first transfer of each size. A wrong address register breaks the stride check on the very next request after an acknowledge. A wrong load accumulator shows only when `done` arrives, as a wrong `result`, or as changed upper bits after a two-byte load. A state machine that leaves its final state late shows within one cycle as a `done` pulse that is too long or comes late.

// File: rtl/altbyte_pkg.sv
package altbyte_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_W     = 32;
    localparam int LONG_N    = REG_W / BYTE_W;
    localparam int WORD_N    = LONG_N / 2;
    localparam int CNT_W     = $clog2(LONG_N);
    localparam int OPC_W     = 16;
    localparam logic [OPC_W-1:0] OPC_MASK = 16'hF1F8;
    localparam logic [OPC_W-1:0] OPC_BASE = 16'h0108;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } abm_state_e;
endpackage

// File: rtl/abm_decode.sv
module abm_decode
    import altbyte_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             valid,
    output logic             is_long,
    output logic             is_store,
    output logic [2:0]       dsel,
    output logic [2:0]       asel
);
    logic [OPC_W-1:0] masked;

    always_comb begin
        masked   = opcode & OPC_MASK;
        // opmode bit 8 is part of the pattern; bits 7,6 are free
        valid    = (masked & ~16'h00C0) == OPC_BASE;
        is_long  = opcode[6];
        is_store = opcode[7];
        dsel     = opcode[11:9];
        asel     = opcode[2:0];
    end
endmodule

// File: rtl/abm_byte_lane.sv
module abm_byte_lane
    import altbyte_pkg::*;
(
    input  logic [REG_W-1:0]  data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              is_long,
    input  logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] wbyte,
    output logic [REG_W-1:0]  merged
);
    always_comb begin
        // remaining-count indexes the lane: highest lane leaves first
        wbyte = data[cnt*BYTE_W +: BYTE_W];
        if (is_long) begin
            merged = {data[REG_W-BYTE_W-1:0], rdata};
        end else begin
            merged = {data[REG_W-1:REG_W/2], data[BYTE_W-1:0], rdata};
        end
    end
endmodule

// File: rtl/altbyte_move_seq.sv
module altbyte_move_seq
    import altbyte_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ADDR_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       opcode,
    input  logic [15:0]       disp,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [31:0]       dreg_val,
    output logic [2:0]        areg_sel,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              result_we,
    output logic [31:0]       result,
    output logic [2:0]        result_sel
);
    localparam int EXT_W = ADDR_W - OPC_W;

    typedef struct packed {
        abm_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              lng;
        logic [2:0]        dsel;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             dec_valid, dec_long, dec_store;
    logic [2:0]       dec_dsel;
    logic [BYTE_W-1:0] lane_byte;
    logic [REG_W-1:0]  lane_merged;

    abm_decode u_dec (
        .opcode  (opcode),
        .valid   (dec_valid),
        .is_long (dec_long),
        .is_store(dec_store),
        .dsel    (dec_dsel),
        .asel    (areg_sel)
    );

    abm_byte_lane u_lane (
        .data   (seq_q.data),
        .cnt    (seq_q.cnt),
        .is_long(seq_q.lng),
        .rdata  (mem_rdata),
        .wbyte  (lane_byte),
        .merged (lane_merged)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start && dec_valid) begin
                    seq_d.state = ST_XFER;
                    seq_d.addr  = areg_val + {{EXT_W{disp[15]}}, disp};
                    seq_d.data  = dreg_val;
                    seq_d.cnt   = dec_long ? CNT_W'(LONG_N - 1) : CNT_W'(WORD_N - 1);
                    seq_d.wr    = dec_store;
                    seq_d.lng   = dec_long;
                    seq_d.dsel  = dec_dsel;
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (!seq_q.wr) begin
                        seq_d.data = lane_merged;
                    end
                    if (seq_q.cnt == '0) begin
                        seq_d.state = ST_FIN;
                    end else begin
                        seq_d.cnt  = seq_q.cnt - 1'b1;
                        seq_d.addr = seq_q.addr + ADDR_W'(ADDR_STEP);
                    end
                end
            end
            ST_FIN: begin
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, addr: '0, data: '0, cnt: '0,
                       wr: 1'b0, lng: 1'b0, dsel: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy       = seq_q.state != ST_IDLE;
    assign done       = seq_q.state == ST_FIN;
    assign mem_req    = seq_q.state == ST_XFER;
    assign mem_we     = seq_q.wr;
    assign mem_addr   = seq_q.addr;
    assign mem_wdata  = lane_byte;
    assign result     = seq_q.data;
    assign result_we  = done && !seq_q.wr;
    assign result_sel = seq_q.dsel;
endmodule

// File: rtl/abm_checker.sv
module abm_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              result_we
);
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ack)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(2)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ack));

    p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || done) |-> busy);

    p_wb_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_we |-> done);
endmodule

bind altbyte_move_seq abm_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_altbyte_move_seq.sv
`timescale 1ns/1ps
module tb_altbyte_move_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] disp = '0;
    logic [31:0] areg_val = '0;
    logic [31:0] dreg_val = '0;
    logic [2:0]  areg_sel;
    logic        busy, done, mem_req, mem_we, result_we;
    logic [31:0] mem_addr, result;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  result_sel;

    altbyte_move_seq dut (.*);

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wait_cyc = 0;
    int wcnt = 0;
    int last_ack_cyc = 0;
    int done_cyc = 0;
    int nlog = 0;
    logic [31:0] log_addr [0:7];
    logic [7:0]  log_data [0:7];
    logic        log_we   [0:7];
    logic [7:0]  mem [0:255];

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= wait_cyc) begin
                    mem_ack = 1'b1;
                    if (nlog < 8) begin
                        log_addr[nlog] = mem_addr;
                        log_data[nlog] = mem_we ? mem_wdata : mem[mem_addr[7:0]];
                        log_we[nlog]   = mem_we;
                    end
                    nlog = nlog + 1;
                    if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                    else        mem_rdata = mem[mem_addr[7:0]];
                    last_ack_cyc = cyc;
                end else begin
                    wcnt = wcnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_op(input logic [2:0] d, input logic [2:0] om,
                                          input logic [2:0] a);
        return {4'b0000, d, om, 3'b001, a};
    endfunction

    // issue one instruction and wait for completion; returns 1 on done
    task automatic run_op(input logic [15:0] op, input logic [15:0] dv,
                          input logic [31:0] av, input logic [31:0] rv,
                          output bit got_done);
        @(negedge clk);
        opcode = op; disp = dv; areg_val = av; dreg_val = rv;
        start = 1'b1; nlog = 0;
        @(negedge clk);
        start = 1'b0;
        got_done = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin got_done = 1'b1; done_cyc = cyc; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(!busy, "R10", "busy after reset", 32'(busy), 0);
        chk(!done, "R9", "done after reset", 32'(done), 0);
        chk(!mem_req, "R10", "req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_long_store;
        bit g;
        logic [7:0] exp_b [0:3];
        exp_b[0] = 8'hA1; exp_b[1] = 8'hB2; exp_b[2] = 8'hC3; exp_b[3] = 8'hD4;
        wait_cyc = 2;
        opcode = mk_op(3'd3, 3'b111, 3'd5);
        #0.1;
        chk(areg_sel == 3'd5, "R2", "areg_sel", 32'(areg_sel), 5);
        run_op(mk_op(3'd3, 3'b111, 3'd5), 16'h0010, 32'h100, 32'hA1B2C3D4, g);
        chk(g, "R9", "long store done", 32'(g), 1);
        chk(nlog == 4, "R3", "long store access count", nlog, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_addr[i] == 32'h110 + 2*i, "R5", "store address", log_addr[i], 32'h110 + 2*i);
            chk(log_data[i] == exp_b[i], "R6", "store byte order", log_data[i], exp_b[i]);
            chk(log_we[i], "R3", "store direction", 32'(log_we[i]), 1);
        end
        chk(done_cyc == last_ack_cyc + 1, "R9", "done timing", done_cyc, last_ack_cyc + 1);
        chk(!result_we, "R9", "no write-back on store", 32'(result_we), 0);
        @(negedge clk);
        chk(!done && !busy, "R9", "done single pulse", 32'({done, busy}), 0);
    endtask

    task automatic t_word_store;
        bit g;
        wait_cyc = 0;
        run_op(mk_op(3'd1, 3'b110, 3'd2), 16'h0003, 32'h20, 32'h12345678, g);
        chk(nlog == 2, "R3", "word store access count", nlog, 2);
        chk(log_addr[0] == 32'h23 && log_addr[1] == 32'h25, "R5", "word store addresses",
            {log_addr[0][15:0], log_addr[1][15:0]}, 32'h00230025);
        chk(log_data[0] == 8'h56 && log_data[1] == 8'h78, "R6", "word store bytes",
            {16'h0, log_data[0], log_data[1]}, 32'h5678);
    endtask

    task automatic t_long_load;
        bit g;
        mem[8'hF0] = 8'h11; mem[8'hF2] = 8'h22; mem[8'hF4] = 8'h33; mem[8'hF6] = 8'h44;
        wait_cyc = 1;
        run_op(mk_op(3'd6, 3'b101, 3'd0), 16'hFFF0, 32'h200, 32'hFFFFFFFF, g);
        chk(log_addr[0] == 32'h1F0, "R4", "negative displacement", log_addr[0], 32'h1F0);
        chk(!log_we[0], "R3", "load direction", 32'(log_we[0]), 0);
        chk(result == 32'h11223344, "R7", "long load result", result, 32'h11223344);
        chk(result_we, "R9", "write-back on load", 32'(result_we), 1);
        chk(result_sel == 3'd6, "R2", "result_sel", 32'(result_sel), 6);
    endtask

    task automatic t_word_load;
        bit g;
        mem[8'h41] = 8'h5A; mem[8'h43] = 8'hC3;
        wait_cyc = 0;
        run_op(mk_op(3'd7, 3'b100, 3'd1), 16'h0010, 32'h31, 32'hDEAD0000, g);
        chk(nlog == 2, "R3", "word load access count", nlog, 2);
        chk(result == 32'hDEAD5AC3, "R7", "word load keeps upper half", result, 32'hDEAD5AC3);
    endtask

    task automatic t_bad_opcode;
        // bit-operation pattern 0x0100 / 0x0140 style: mode field 000
        @(negedge clk);
        opcode = 16'h0140; disp = 16'h0; areg_val = 32'h80; start = 1'b1; nlog = 0;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R1", "non-matching opcode busy", 32'(busy), 0);
        repeat (3) @(negedge clk);
        chk(nlog == 0, "R1", "non-matching opcode accesses", nlog, 0);
    endtask

    task automatic t_restart_ignored;
        bit g;
        wait_cyc = 3;
        @(negedge clk);
        opcode = mk_op(3'd2, 3'b111, 3'd3); disp = 16'h0; areg_val = 32'h60;
        dreg_val = 32'h01020304; start = 1'b1; nlog = 0;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10", "busy after start", 32'(busy), 1);
        repeat (2) @(negedge clk);
        opcode = mk_op(3'd4, 3'b110, 3'd3); areg_val = 32'h90; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        g = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin g = 1'b1; break; end
            @(negedge clk);
        end
        chk(g, "R10", "first transfer completes", 32'(g), 1);
        chk(nlog == 4, "R10", "restart ignored count", nlog, 4);
        chk(log_addr[3] == 32'h66 && log_data[3] == 8'h04, "R10", "restart ignored last access",
            log_addr[3], 32'h66);
        @(negedge clk);
        chk(!busy, "R10", "idle after done", 32'(busy), 0);
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_long_store;
        t_word_store;
        t_long_load;
        t_word_load;
        t_bad_opcode;
        t_restart_ignored;
        report;
        $finish;
    end

    initial begin
        #100000;
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: actual=hung expected=finished");
        report;
        $finish;
    end
endmodule